// File: doc/BRIEF.md
# Windowed-Warning Watchdog Timer

This block is a watchdog that counts input clocks while it is enabled. Software picks one of four interval lengths, and it must issue a restart before the interval runs out. If the interval expires, the block raises a warning flag first, and it can also raise an interrupt request. A fixed grace period follows. If no restart arrives during that period, the block emits a one-clock reset pulse and sets a sticky flag. Software reads that flag after the reset to learn where the reset came from.

The enable bit is guarded. A write to it takes effect only while an unlock qualifier is high. The unlock sequence that drives this qualifier is assumed to be elsewhere on the chip. The interval select is captured when a restart is issued, so a count already running is never cut short. A restart clears the warning flag and the grace count. After a watchdog reset the counter starts a fresh full interval on its own.

Top module: `wdt_windowed`

## Requirements
- R1: After power-on reset the enable bit is off and the outputs irq, warn_flag, wdrst_flag and wd_rst are all 0.
- R2: A write to the enable bit (en_wr high) changes it only when en_unlock is high in the same cycle. The counters advance only while the enable bit is set and hold their value while it is clear.
- R3: With tsel = s captured at a restart, warn_flag rises exactly 2^(BASE_LOG2 + STEP_LOG2*s) enabled clocks after the restart edge. The defaults give 2^17, 2^20, 2^23 and 2^26 for s = 0, 1, 2, 3.
- R4: If no restart arrives, wd_rst goes high exactly GRACE_CLKS (default 512) enabled clocks after warn_flag was set, for exactly one clock. This happens whatever the value of irq_en.
- R5: irq equals warn_flag AND irq_en, with no added delay.
- R6: wdrst_flag is set in the same cycle that wd_rst is high. It stays set until clr_rstflag is high with no new watchdog reset in that cycle. A set in the same cycle as a clear wins.
- R7: A restart clears warn_flag and the grace count and begins a full interval. A restart during the grace period cancels the reset, even when it lands on the very cycle the reset would fire.
- R8: clr_warn clears warn_flag. When an expiry falls in the same cycle as clr_warn, warn_flag ends up set.
- R9: A change on tsel takes effect only at the next restart. The running interval keeps the length captured at its restart.
- R10: After a watchdog reset the counter starts a new full interval by itself, and warn_flag rises again at its end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| en_unlock | input | 1 | Qualifier that must be high for an enable write to take effect |
| restart | input | 1 | One-cycle strobe that starts a new full interval |
| tsel | input | SEL_W | Interval select, captured at restart |
| irq_en | input | 1 | Gates warn_flag onto irq |
| clr_warn | input | 1 | Clears warn_flag |
| clr_rstflag | input | 1 | Clears wdrst_flag |
| irq | output | 1 | Interrupt request |
| warn_flag | output | 1 | Interval expired; grace period running or done |
| wdrst_flag | output | 1 | Sticky record that a watchdog reset happened |
| wd_rst | output | 1 | One-clock reset pulse |

## Verification
Two events can land on the same edge: a restart and the last cycle of the grace period. The bench issues a restart on exactly the edge where the reset would fire, then checks that wd_rst stays low, wdrst_flag stays clear and warn_flag drops. In the same way, clr_warn is driven on the expiry edge and clr_rstflag on the firing edge, and the bench checks that the set wins in both cases. Random stimulus then drives restarts, locked and unlocked enable writes, flag clears and select changes, sometimes all in one cycle. Every output is compared each cycle against a bench model built from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {
      PH_COUNT = 1'b0,
      PH_GRACE = 1'b1
   } wdt_phase_e;

   // log2 of the interval length chosen by select value sel
   function automatic int unsigned interval_log2(int unsigned base, int unsigned step,
                                                 int unsigned sel);
      return base + step * sel;
   endfunction
endpackage

// File: rtl/wdt_lock_reg.sv
module wdt_lock_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wdata,
   input  logic unlock,
   output logic en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (wr && unlock)
         en_q <= wdata;
   end
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval
   import wdt_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 17,
   parameter int unsigned STEP_LOG2 = 3,
   parameter int unsigned SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [SEL_W-1:0] tsel,
   output logic             expire
);
   localparam int unsigned NSEL    = 1 << SEL_W;
   localparam int unsigned MAX_LOG = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);
   localparam int unsigned CW      = MAX_LOG;

   generate
      if (BASE_LOG2 < 1) begin : g_bad_base
         $error("wdt_interval: BASE_LOG2 must be at least 1");
      end
      if (MAX_LOG > 62) begin : g_bad_max
         $error("wdt_interval: longest interval exceeds 2^62");
      end
   endgenerate

   logic [CW-1:0]    cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic [NSEL-1:0]  at_term;

   generate
      for (genvar i = 0; i < NSEL; i++) begin : g_term
         localparam int unsigned LG = interval_log2(BASE_LOG2, STEP_LOG2, i);
         localparam logic [CW-1:0] TERM = {CW{1'b1}} >> (CW - LG);
         assign at_term[i] = (cnt_q == TERM);
      end
   endgenerate

   assign expire = run && !restart && at_term[sel_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sel_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
         sel_q <= tsel;
      end else if (run) begin
         cnt_q <= expire ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_grace.sv
module wdt_grace #(
   parameter int unsigned GRACE_CLKS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic fire
);
   localparam int unsigned GW = (GRACE_CLKS > 1) ? $clog2(GRACE_CLKS) : 1;
   localparam logic [GW-1:0] LAST = GW'(GRACE_CLKS - 1);

   generate
      if (GRACE_CLKS < 2) begin : g_bad_grace
         $error("wdt_grace: GRACE_CLKS must be at least 2");
      end
   endgenerate

   logic [GW-1:0] g_q;

   assign fire = run && !restart && (g_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         g_q <= '0;
      else if (restart)
         g_q <= '0;
      else if (run)
         g_q <= fire ? '0 : g_q + 1'b1;
   end
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
   import wdt_pkg::*;
#(
   parameter int unsigned BASE_LOG2  = 17,
   parameter int unsigned STEP_LOG2  = 3,
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned GRACE_CLKS = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             en_wdata,
   input  logic             en_unlock,
   input  logic             restart,
   input  logic [SEL_W-1:0] tsel,
   input  logic             irq_en,
   input  logic             clr_warn,
   input  logic             clr_rstflag,
   output logic             irq,
   output logic             warn_flag,
   output logic             wdrst_flag,
   output logic             wd_rst
);
   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("wdt_windowed: SEL_W must be at least 1");
      end
   endgenerate

   logic       en_q;
   wdt_phase_e phase_q;
   logic       run_cnt, run_gr, expire, fire;

   wdt_lock_reg u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (en_wr),
      .wdata  (en_wdata),
      .unlock (en_unlock),
      .en_q   (en_q)
   );

   assign run_cnt = en_q && (phase_q == PH_COUNT);
   assign run_gr  = en_q && (phase_q == PH_GRACE);

   wdt_interval #(
      .BASE_LOG2 (BASE_LOG2),
      .STEP_LOG2 (STEP_LOG2),
      .SEL_W     (SEL_W)
   ) u_interval (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_cnt),
      .restart (restart),
      .tsel    (tsel),
      .expire  (expire)
   );

   wdt_grace #(
      .GRACE_CLKS (GRACE_CLKS)
   ) u_grace (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_gr),
      .restart (restart),
      .fire    (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= PH_COUNT;
      else if (restart)
         phase_q <= PH_COUNT;
      else if (expire)
         phase_q <= PH_GRACE;
      else if (fire)
         phase_q <= PH_COUNT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_flag  <= 1'b0;
         wdrst_flag <= 1'b0;
         wd_rst     <= 1'b0;
      end else begin
         if (expire)
            warn_flag <= 1'b1;
         else if (restart || clr_warn)
            warn_flag <= 1'b0;
         if (fire)
            wdrst_flag <= 1'b1;
         else if (clr_rstflag)
            wdrst_flag <= 1'b0;
         wd_rst <= fire;
      end
   end

   assign irq = warn_flag && irq_en;
endmodule

// File: rtl/wdt_windowed_chk.sv
module wdt_windowed_chk (
   input logic clk,
   input logic rst_n,
   input logic en_wr,
   input logic en_unlock,
   input logic restart,
   input logic clr_rstflag,
   input logic en_q,
   input logic warn_flag,
   input logic wdrst_flag,
   input logic wd_rst
);
   // R4
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |=> !wd_rst);

   // R6
   flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |-> wdrst_flag);

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wdrst_flag && !clr_rstflag) |=> wdrst_flag);

   // R7
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!warn_flag && !wd_rst));

   // R2
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_wr && en_unlock) |=> $stable(en_q));
endmodule

bind wdt_windowed wdt_windowed_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_wr       (en_wr),
   .en_unlock   (en_unlock),
   .restart     (restart),
   .clr_rstflag (clr_rstflag),
   .en_q        (en_q),
   .warn_flag   (warn_flag),
   .wdrst_flag  (wdrst_flag),
   .wd_rst      (wd_rst)
);

// File: tb/wdt_windowed_tb.sv
module wdt_windowed_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BASE = 3;
   localparam int STEP = 1;
   localparam int GR   = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_wr = 0, en_wdata = 0, en_unlock = 0, restart = 0;
   logic [1:0] tsel = 0;
   logic       irq_en = 0, clr_warn = 0, clr_rstflag = 0;
   logic       irq, warn_flag, wdrst_flag, wd_rst;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_windowed #(
      .BASE_LOG2  (BASE),
      .STEP_LOG2  (STEP),
      .SEL_W      (2),
      .GRACE_CLKS (GR)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .en_wr (en_wr), .en_wdata (en_wdata),
      .en_unlock (en_unlock), .restart (restart), .tsel (tsel), .irq_en (irq_en),
      .clr_warn (clr_warn), .clr_rstflag (clr_rstflag), .irq (irq),
      .warn_flag (warn_flag), .wdrst_flag (wdrst_flag), .wd_rst (wd_rst)
   );

   function automatic int interval_len(int sel);
      return 1 << (BASE + STEP * sel);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic adv(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic en_write(input bit v, input bit unl);
      en_wr = 1; en_wdata = v; en_unlock = unl;
      adv(1);
      en_wr = 0; en_unlock = 0;
   endtask

   task automatic do_restart(input int sel);
      restart = 1; tsel = 2'(sel);
      adv(1);
      restart = 0;
   endtask

   // Cycle model built from the requirements
   bit m_en, m_gr, m_warn, m_flag, m_pulse, set_w, set_f;
   int m_el, m_g, m_sel;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_gr = 0; m_warn = 0; m_flag = 0; m_pulse = 0;
         m_el = 0; m_g = 0; m_sel = 0;
      end else begin
         set_w = 0; set_f = 0; m_pulse = 0;
         if (restart) begin
            m_el = 0; m_g = 0; m_gr = 0; m_warn = 0; m_sel = int'(tsel);
         end else if (m_en) begin
            if (!m_gr) begin
               m_el++;
               if (m_el == interval_len(m_sel)) begin
                  set_w = 1; m_gr = 1; m_g = 0; m_el = 0;
               end
            end else begin
               m_g++;
               if (m_g == GR) begin
                  set_f = 1; m_pulse = 1; m_gr = 0; m_el = 0;
               end
            end
         end
         if (set_w) m_warn = 1; else if (clr_warn) m_warn = 0;
         if (set_f) m_flag = 1; else if (clr_rstflag) m_flag = 0;
         if (en_wr && en_unlock) m_en = en_wdata;
      end
      #2;
      if (rst_n) begin
         chk(warn_flag == m_warn, "R3", "model warn_flag", warn_flag, m_warn);
         chk(wd_rst == m_pulse, "R4", "model wd_rst", wd_rst, m_pulse);
         chk(wdrst_flag == m_flag, "R6", "model wdrst_flag", wdrst_flag, m_flag);
         chk(irq == (m_warn & irq_en), "R5", "model irq", irq, m_warn & irq_en);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      adv(3);
      rst_n = 1;
      adv(1);
      // R1 reset state
      chk(!irq && !warn_flag && !wdrst_flag && !wd_rst, "R1", "outputs after reset",
          {irq, warn_flag, wdrst_flag, wd_rst}, 0);

      // R2 locked enable write is ignored
      en_write(1, 0);
      do_restart(0);
      adv(20);
      chk(warn_flag == 0, "R2", "warn with locked enable", warn_flag, 0);

      // R3/R4/R5/R6/R8/R10 basic timeout path
      en_write(1, 1);
      irq_en = 0;
      do_restart(0);
      adv(7);
      chk(warn_flag == 0, "R3", "warn one before interval", warn_flag, 0);
      adv(1);
      chk(warn_flag == 1, "R3", "warn at interval", warn_flag, 1);
      chk(irq == 0, "R5", "irq gated off", irq, 0);
      irq_en = 1;
      #1;
      chk(irq == 1, "R5", "irq gated on", irq, 1);
      adv(5);
      chk(wd_rst == 0, "R4", "pulse one before grace end", wd_rst, 0);
      clr_rstflag = 1;
      adv(1);
      clr_rstflag = 0;
      chk(wd_rst == 1, "R4", "pulse at grace end", wd_rst, 1);
      chk(wdrst_flag == 1, "R6", "flag set beats clear", wdrst_flag, 1);
      adv(1);
      chk(wd_rst == 0, "R4", "pulse one clock wide", wd_rst, 0);
      chk(wdrst_flag == 1, "R6", "flag sticky", wdrst_flag, 1);
      clr_warn = 1;
      adv(1);
      clr_warn = 0;
      chk(warn_flag == 0, "R8", "warn cleared", warn_flag, 0);
      adv(5);
      chk(warn_flag == 0, "R10", "no warn before new interval", warn_flag, 0);
      adv(1);
      chk(warn_flag == 1, "R10", "warn after auto interval", warn_flag, 1);
      clr_rstflag = 1;
      adv(1);
      clr_rstflag = 0;
      chk(wdrst_flag == 0, "R6", "flag cleared", wdrst_flag, 0);

      // R7 restart in grace, R8 set beats clear, R7 restart on firing edge
      do_restart(0);
      chk(warn_flag == 0, "R7", "restart clears warn", warn_flag, 0);
      adv(7);
      clr_warn = 1;
      adv(1);
      clr_warn = 0;
      chk(warn_flag == 1, "R8", "expiry beats clear", warn_flag, 1);
      adv(5);
      do_restart(0);
      chk(wd_rst == 0, "R7", "restart on firing edge blocks pulse", wd_rst, 0);
      chk(warn_flag == 0, "R7", "restart on firing edge clears warn", warn_flag, 0);
      adv(2);
      chk(wdrst_flag == 0, "R7", "no reset recorded", wdrst_flag, 0);

      // R9 select captured at restart
      do_restart(1);
      adv(2);
      tsel = 0;
      adv(13);
      chk(warn_flag == 0, "R9", "old length kept", warn_flag, 0);
      adv(1);
      chk(warn_flag == 1, "R9", "warn at captured length", warn_flag, 1);

      // R3 longest select
      do_restart(3);
      adv(interval_len(3) - 1);
      chk(warn_flag == 0, "R3", "sel3 one before", warn_flag, 0);
      adv(1);
      chk(warn_flag == 1, "R3", "sel3 at interval", warn_flag, 1);

      // R2 count holds while disabled
      do_restart(0);
      adv(3);
      en_write(0, 1);
      adv(9);
      en_write(1, 1);
      adv(3);
      chk(warn_flag == 0, "R2", "count held while disabled", warn_flag, 0);
      adv(1);
      chk(warn_flag == 1, "R2", "count resumes", warn_flag, 1);

      // random phase, compared by the model every cycle
      for (int i = 0; i < 4000; i++) begin
         restart     = ($urandom_range(0, 99) == 0);
         en_wr       = ($urandom_range(0, 49) == 0);
         en_unlock   = ($urandom_range(0, 1) == 0);
         en_wdata    = ($urandom_range(0, 3) != 0);
         tsel        = 2'($urandom_range(0, 3));
         clr_warn    = ($urandom_range(0, 29) == 0);
         clr_rstflag = ($urandom_range(0, 59) == 0);
         if ($urandom_range(0, 19) == 0) irq_en = ~irq_en;
         adv(1);
      end
      restart = 0; en_wr = 0; en_unlock = 0; clr_warn = 0; clr_rstflag = 0;
      adv(2);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule